// File: doc/BRIEF.md
# Atomic Fetch-and-Add Sequencer

This block carries out one atomic fetch-and-add instruction against a single-ported memory. It takes a 32-bit instruction word with a start strobe and decodes the fixed operation pattern. It reads the addend register and the base register from an external 64-bit register file. It then runs a locked read-modify-write: the memory location is read, the addend is added, and the sum is written back. The value that memory held before the add is returned to the destination register.

The access is a 32-bit word or a 64-bit doubleword. Register index 31 has two meanings. As the base, it selects a separate stack-pointer input, which must be 16-byte aligned. As the destination, it discards the loaded value.

The sequence always walks through four states:
- IDLE to READ, on an accepted start.
- READ to WRITE, unconditionally.
- WRITE to WB, unconditionally.
- WB to IDLE, unconditionally.

A start that is not accepted leaves the block in IDLE and raises a one-cycle indication. This happens for a bad pattern or a misaligned address.

Top module: `afa_unit`

## Requirements
- R1: An instruction word is legal only if `(instr & 0xBFE0FC00) == 0xB8200000`. The addend register index is in bits [20:16], the base index in [9:5] and the destination index in [4:0]. On a start with an illegal word:
  - `illegal` is high for exactly the one cycle after the start edge.
  - No memory access and no register write follow.
- R2: Instruction bit 30 selects the access size: 0 for a 32-bit word, 1 for a 64-bit doubleword. `mem_dword` reports the size during the access.
- R3: Memory receives the old value plus the addend, wrapping modulo 2^32 or 2^64 according to the size. For a word access, only the low 32 bits of the addend are used, and only the addressed 4 bytes change.
- R4: The destination receives the old memory value, not the sum. For a word access, bits [63:32] of the written value are zero.
- R5: When the destination index is 31, `wb_en` stays low for the whole sequence. The memory update still happens.
- R6: When the base index is 31, the address comes from `sp_in`, and `sp_in` must be 16-byte aligned.
- R7: A general-register address must be 4-byte aligned for a word access and 8-byte aligned for a doubleword access. On a misaligned address:
  - `align_fault` is high for the one cycle after the start edge.
  - No memory access and no register write follow.
- R8: An accepted start takes exactly three busy cycles:
  - READ: a read, with `mem_req` high and `mem_we` low.
  - WRITE: a write, with `mem_req` and `mem_we` both high.
  - WB: the register write-back, with no memory request.

  `mem_lock` is high whenever `mem_req` is high.
- R9: Address computation wraps naturally: any 64-bit base, including the top of the address space, is used unchanged.
- R10: After reset, the following are all low: `busy`, `mem_req`, `mem_lock`, `wb_en`, `illegal` and `align_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Instruction valid; sampled only in IDLE |
| instr | input | 32 | Instruction word |
| rf_src_idx | output | 5 | Addend register read index (from instr) |
| rf_src_data | input | 64 | Addend register value |
| rf_base_idx | output | 5 | Base register read index (from instr) |
| rf_base_data | input | 64 | Base register value |
| sp_in | input | 64 | Stack-pointer value used when base index is 31 |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write when high, read when low |
| mem_dword | output | 1 | Access size: 1 doubleword, 0 word |
| mem_lock | output | 1 | Memory held for this requester |
| mem_addr | output | 64 | Byte address |
| mem_wdata | output | 64 | Write data, right-aligned |
| mem_rdata | input | 64 | Read data, right-aligned, combinational |
| wb_en | output | 1 | Destination register write enable |
| wb_idx | output | 5 | Destination register index |
| wb_data | output | 64 | Destination value (old memory value, zero-extended) |
| busy | output | 1 | High while not in IDLE |
| illegal | output | 1 | One-cycle illegal-instruction pulse |
| align_fault | output | 1 | One-cycle alignment-fault pulse |

## Verification
The bench builds the block at its default 64-bit data and address width and 16-byte stack alignment. At this width both size paths are live, so the word path's truncation of a wide addend is visible against the doubleword path. A base at the top of the 64-bit space can also be driven to exercise address wrap into a small byte-array model. With the 16-byte stack rule, a stack pointer that is 8-byte aligned is still rejected, which separates the stack-pointer check from the general doubleword check.

// File: rtl/afa_pkg.sv
package afa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2,
        ST_WB    = 2'd3
    } afa_state_t;

    localparam int unsigned IDX_W      = 5;
    localparam int unsigned INSTR_W    = 32;
    localparam logic [INSTR_W-1:0] OP_MASK  = 32'hBFE0FC00;
    localparam logic [INSTR_W-1:0] OP_MATCH = 32'hB8200000;
    localparam logic [IDX_W-1:0]   IDX_SPECIAL = 5'd31;

    typedef struct packed {
        logic             dword;
        logic [IDX_W-1:0] src;
        logic [IDX_W-1:0] base;
        logic [IDX_W-1:0] dst;
    } afa_fields_t;

endpackage

// File: rtl/afa_decode.sv
module afa_decode
    import afa_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               legal,
    output afa_fields_t        fields
);
    always_comb begin
        legal        = ((instr & OP_MASK) == OP_MATCH);
        fields.dword = instr[30];
        fields.src   = instr[20:16];
        fields.base  = instr[9:5];
        fields.dst   = instr[4:0];
    end
endmodule

// File: rtl/afa_align.sv
module afa_align #(
    parameter int unsigned ADDR_W      = 64,
    parameter int unsigned SP_ALIGN_LG = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              sp_sel,
    input  logic              dword,
    output logic              ok
);
    localparam int unsigned WORD_LG  = 2;
    localparam int unsigned DWORD_LG = 3;

    logic low_w, low_d, low_sp;

    always_comb begin
        low_w  = (addr[WORD_LG-1:0] == '0);
        low_d  = (addr[DWORD_LG-1:0] == '0);
        low_sp = (addr[SP_ALIGN_LG-1:0] == '0);
        if (sp_sel)
            ok = low_sp && (dword ? low_d : low_w);
        else
            ok = dword ? low_d : low_w;
    end
endmodule

// File: rtl/afa_sum.sv
module afa_sum #(
    parameter int unsigned XLEN = 64
) (
    input  logic [XLEN-1:0] old_val,
    input  logic [XLEN-1:0] addend,
    input  logic            dword,
    output logic [XLEN-1:0] sum
);
    localparam int unsigned HALF = XLEN / 2;

    logic [HALF-1:0] sum_w;
    logic [XLEN-1:0] sum_d;

    always_comb begin
        sum_w = old_val[HALF-1:0] + addend[HALF-1:0];
        sum_d = old_val + addend;
        sum   = dword ? sum_d : {{HALF{1'b0}}, sum_w};
    end
endmodule

// File: rtl/afa_unit.sv
module afa_unit
    import afa_pkg::*;
#(
    parameter int unsigned XLEN        = 64,
    parameter int unsigned SP_ALIGN_LG = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [INSTR_W-1:0]  instr,
    output logic [IDX_W-1:0]    rf_src_idx,
    input  logic [XLEN-1:0]     rf_src_data,
    output logic [IDX_W-1:0]    rf_base_idx,
    input  logic [XLEN-1:0]     rf_base_data,
    input  logic [XLEN-1:0]     sp_in,
    output logic                mem_req,
    output logic                mem_we,
    output logic                mem_dword,
    output logic                mem_lock,
    output logic [XLEN-1:0]     mem_addr,
    output logic [XLEN-1:0]     mem_wdata,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                wb_en,
    output logic [IDX_W-1:0]    wb_idx,
    output logic [XLEN-1:0]     wb_data,
    output logic                busy,
    output logic                illegal,
    output logic                align_fault
);
    localparam int unsigned HALF = XLEN / 2;

    afa_state_t  state, state_nx;
    afa_fields_t fld;
    logic        legal, align_ok, sp_sel, accept;
    logic [XLEN-1:0] addr_sel, sum;

    logic [XLEN-1:0]  addr_q, addend_q, old_q;
    logic             dword_q;
    logic [IDX_W-1:0] dst_q;
    logic             illegal_q, fault_q;

    afa_decode u_dec (
        .instr  (instr),
        .legal  (legal),
        .fields (fld)
    );

    assign sp_sel      = (fld.base == IDX_SPECIAL);
    assign addr_sel    = sp_sel ? sp_in : rf_base_data;
    assign rf_src_idx  = fld.src;
    assign rf_base_idx = fld.base;

    afa_align #(.ADDR_W(XLEN), .SP_ALIGN_LG(SP_ALIGN_LG)) u_align (
        .addr   (addr_sel),
        .sp_sel (sp_sel),
        .dword  (fld.dword),
        .ok     (align_ok)
    );

    afa_sum #(.XLEN(XLEN)) u_sum (
        .old_val (old_q),
        .addend  (addend_q),
        .dword   (dword_q),
        .sum     (sum)
    );

    assign accept = start && legal && align_ok;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept) state_nx = ST_READ;
            ST_READ:  state_nx = ST_WRITE;
            ST_WRITE: state_nx = ST_WB;
            ST_WB:    state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Operand capture and status pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q    <= '0;
            addend_q  <= '0;
            old_q     <= '0;
            dword_q   <= 1'b0;
            dst_q     <= '0;
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
        end else begin
            illegal_q <= 1'b0;
            fault_q   <= 1'b0;
            if (state == ST_IDLE && start) begin
                if (!legal) begin
                    illegal_q <= 1'b1;
                end else if (!align_ok) begin
                    fault_q <= 1'b1;
                end else begin
                    addr_q   <= addr_sel;
                    addend_q <= rf_src_data;
                    dword_q  <= fld.dword;
                    dst_q    <= fld.dst;
                end
            end
            if (state == ST_READ)
                old_q <= dword_q ? mem_rdata : {{HALF{1'b0}}, mem_rdata[HALF-1:0]};
        end
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_lock  = 1'b0;
        wb_en     = 1'b0;
        unique case (state)
            ST_IDLE:  ;
            ST_READ:  begin mem_req = 1'b1; mem_lock = 1'b1; end
            ST_WRITE: begin mem_req = 1'b1; mem_we = 1'b1; mem_lock = 1'b1; end
            ST_WB:    wb_en = (dst_q != IDX_SPECIAL);
            default:  ;
        endcase
        mem_addr    = addr_q;
        mem_dword   = dword_q;
        mem_wdata   = sum;
        wb_idx      = dst_q;
        wb_data     = old_q;
        busy        = (state != ST_IDLE);
        illegal     = illegal_q;
        align_fault = fault_q;
    end

endmodule

// File: rtl/afa_unit_chk.sv
module afa_unit_chk #(
    parameter int unsigned XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            mem_req,
    input logic            mem_we,
    input logic            mem_lock,
    input logic            mem_dword,
    input logic            wb_en,
    input logic [4:0]      wb_idx,
    input logic [XLEN-1:0] wb_data,
    input logic            busy,
    input logic            illegal,
    input logic            align_fault
);
    AST_LOCK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_lock) else $error("lock"); // R8
    AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (mem_req && mem_we)) else $error("rw"); // R8
    AST_WRITE_THEN_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> (busy && !mem_req)) else $error("wb"); // R8
    AST_SIZE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> $stable(mem_dword)) else $error("size"); // R2
    AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (!busy && !mem_req && !align_fault)) else $error("ill"); // R1
    AST_FAULT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        align_fault |-> (!busy && !mem_req)) else $error("flt"); // R7
    AST_WORD_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !mem_dword) |-> (wb_data[XLEN-1:XLEN/2] == '0)) else $error("zx"); // R4
    AST_NO_WB_SPECIAL: assert property (@(posedge clk) disable iff (!rst_n)
        wb_en |-> (wb_idx != 5'd31)) else $error("x31"); // R5
endmodule

bind afa_unit afa_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_lock    (mem_lock),
    .mem_dword   (mem_dword),
    .wb_en       (wb_en),
    .wb_idx      (wb_idx),
    .wb_data     (wb_data),
    .busy        (busy),
    .illegal     (illegal),
    .align_fault (align_fault)
);

// File: tb/afa_unit_tb.sv
module afa_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] instr = '0;
    logic [4:0]  rf_src_idx, rf_base_idx, wb_idx;
    logic [63:0] rf_src_data, rf_base_data, sp_in, mem_addr, mem_wdata, mem_rdata, wb_data;
    logic        mem_req, mem_we, mem_dword, mem_lock, wb_en, busy, illegal, align_fault;

    logic [63:0] rf [0:31];
    logic [7:0]  mem [0:255];
    int          n_checks = 0, n_fail = 0;
    int          n_acc = 0, n_wb = 0, n_busy = 0;
    logic        s_ill, s_flt;

    always #4 clk = ~clk;

    afa_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .instr(instr),
        .rf_src_idx(rf_src_idx), .rf_src_data(rf_src_data),
        .rf_base_idx(rf_base_idx), .rf_base_data(rf_base_data), .sp_in(sp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_dword(mem_dword), .mem_lock(mem_lock),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .busy(busy), .illegal(illegal), .align_fault(align_fault)
    );

    assign rf_src_data  = (rf_src_idx == 5'd31) ? 64'd0 : rf[rf_src_idx];
    assign rf_base_data = (rf_base_idx == 5'd31) ? 64'd0 : rf[rf_base_idx];

    always_comb begin
        mem_rdata = '0;
        for (int b = 0; b < 8; b++)
            if (b < 4 || mem_dword)
                mem_rdata[8*b +: 8] = mem[8'(mem_addr[7:0] + 8'(b))];
    end

    always @(posedge clk) begin
        if (mem_req) n_acc <= n_acc + 1;
        if (mem_req && mem_we)
            for (int b = 0; b < 8; b++)
                if (b < 4 || mem_dword)
                    mem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
        if (wb_en) begin
            n_wb <= n_wb + 1;
            rf[wb_idx] <= wb_data;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input logic dw, input logic [4:0] rs,
                                        input logic [4:0] rn, input logic [4:0] rt);
        return {1'b1, dw, 9'b111000001, rs, 6'b000000, rn, rt};
    endfunction

    function automatic logic [63:0] rd_mem(input logic [7:0] a, input int nbytes);
        logic [63:0] v = '0;
        for (int b = 0; b < nbytes; b++) v[8*b +: 8] = mem[8'(a + 8'(b))];
        return v;
    endfunction

    task automatic wr_mem(input logic [7:0] a, input logic [63:0] v);
        for (int b = 0; b < 8; b++) mem[8'(a + 8'(b))] = v[8*b +: 8];
    endtask

    task automatic issue(input logic [31:0] w);
        n_acc = 0; n_wb = 0; n_busy = 0;
        @(negedge clk); start = 1'b1; instr = w;
        @(negedge clk); start = 1'b0;
        s_ill = illegal; s_flt = align_fault;
        while (busy && n_busy < 20) begin n_busy++; @(negedge clk); end
        @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R10 busy", 64'(busy), 0);
        chk("R10 req", 64'({mem_req, mem_lock, wb_en}), 0);
        chk("R10 flags", 64'({illegal, align_fault}), 0);
    endtask

    task automatic t_word;
        rf[1] = 64'h10; rf[2] = 64'h12345678_00000005; rf[3] = 64'hDEAD;
        wr_mem(8'h10, 64'hAAAAAAAA_FFFFFFFE);
        issue(enc(1'b0, 5'd2, 5'd1, 5'd3));
        chk("R3 word wrap sum", rd_mem(8'h10, 4), 64'h3);
        chk("R3 upper bytes kept", rd_mem(8'h14, 4), 64'hAAAAAAAA);
        chk("R4 old zero-ext", rf[3], 64'hFFFFFFFE);
        chk("R8 busy cycles", 64'(n_busy), 3);
        chk("R8 two accesses", 64'(n_acc), 2);
    endtask

    task automatic t_dword;
        rf[4] = 64'h20; rf[5] = 64'd2; rf[6] = 64'h0;
        wr_mem(8'h20, 64'hFFFFFFFF_FFFFFFFF);
        issue(enc(1'b1, 5'd5, 5'd4, 5'd6));
        chk("R2 R3 dword sum", rd_mem(8'h20, 8), 64'h1);
        chk("R4 dword old", rf[6], 64'hFFFFFFFF_FFFFFFFF);
    endtask

    task automatic t_high_addr;
        rf[7] = 64'hFFFFFFFF_FFFFFFF8; rf[8] = 64'h00000001_00000000; rf[9] = 64'h0;
        wr_mem(8'hF8, 64'h11111111_22222222);
        issue(enc(1'b1, 5'd8, 5'd7, 5'd9));
        chk("R9 top address sum", rd_mem(8'hF8, 8), 64'h11111112_22222222);
        chk("R9 top address old", rf[9], 64'h11111111_22222222);
    endtask

    task automatic t_dst31;
        rf[1] = 64'h30; rf[2] = 64'd7;
        wr_mem(8'h30, 64'd100);
        issue(enc(1'b1, 5'd2, 5'd1, 5'd31));
        chk("R5 no write-back", 64'(n_wb), 0);
        chk("R5 memory still updated", rd_mem(8'h30, 8), 64'd107);
    endtask

    task automatic t_sp_ok;
        sp_in = 64'h40; rf[2] = 64'd5; rf[10] = 64'h0;
        wr_mem(8'h40, 64'd10);
        issue(enc(1'b0, 5'd2, 5'd31, 5'd10));
        chk("R6 sp base sum", rd_mem(8'h40, 4), 64'd15);
        chk("R6 sp base old", rf[10], 64'd10);
    endtask

    task automatic t_sp_bad;
        sp_in = 64'h48; rf[10] = 64'h55;
        wr_mem(8'h48, 64'd10);
        issue(enc(1'b1, 5'd2, 5'd31, 5'd10));
        chk("R6 sp misaligned fault", 64'(s_flt), 1);
        chk("R6 no access", 64'(n_acc + n_wb), 0);
        chk("R6 mem untouched", rd_mem(8'h48, 8), 64'd10);
        chk("R6 dst untouched", rf[10], 64'h55);
    endtask

    task automatic t_misalign;
        rf[1] = 64'h52; rf[11] = 64'h66;
        issue(enc(1'b0, 5'd2, 5'd1, 5'd11));
        chk("R7 word fault", 64'(s_flt), 1);
        chk("R7 word no access", 64'(n_acc + n_wb), 0);
        rf[1] = 64'h64;
        issue(enc(1'b1, 5'd2, 5'd1, 5'd11));
        chk("R7 dword fault", 64'(s_flt), 1);
        chk("R7 dst untouched", rf[11], 64'h66);
        chk("R7 fault one cycle", 64'(align_fault), 0);
    endtask

    task automatic t_illegal;
        rf[1] = 64'h70; rf[12] = 64'h77;
        wr_mem(8'h70, 64'd9);
        issue(enc(1'b1, 5'd2, 5'd1, 5'd12) | 32'h0080_0000);
        chk("R1 illegal pulse", 64'(s_ill), 1);
        chk("R1 no access", 64'(n_acc + n_wb + n_busy), 0);
        chk("R1 mem untouched", rd_mem(8'h70, 8), 64'd9);
        chk("R1 pulse one cycle", 64'(illegal), 0);
        issue(enc(1'b1, 5'd2, 5'd1, 5'd12) | 32'h0000_0400);
        chk("R1 low field illegal", 64'(s_ill), 1);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) rf[i] = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        sp_in = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_word();
        t_dword();
        t_high_addr();
        t_dst31();
        t_sp_ok();
        t_sp_bad();
        t_misalign();
        t_illegal();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule